// File: doc/BRIEF.md
# Return-Address Stack for the Link Register

This block stands in for general-purpose register 1 of a small processor core. Register 1 does not hold one value here: it holds a last-in-first-out stack of return addresses kept in hardware. A jump that names register 1 as its destination pushes the link address, which is the address of the next instruction (PC+4). A register jump that uses register 1 as its base pops the top entry, and that entry is the jump target. Nested subroutine calls then need no software code to save and restore the return address.

The core's execute stage presents each resolved jump for one cycle. It gives the kind of jump, the destination and base register indices, and the jump's PC. In the same cycle the block drives the current top of stack, which is the target of any pop. Pushes, pops and errors take effect at the next rising clock edge. Two sticky error flags record a push onto a full stack and a pop from an empty stack. The stack depth is a parameter.

Top module: `ret_addr_stack`

## Requirements
- R1: A PC-relative jump (jump_reg_i=0) with rd_i=1 pushes pc_i+4. After the next edge depth_o has risen by one and ra_o equals pc_i+4.
- R2: A register jump (jump_reg_i=1) with rs1_i=1 and rd_i other than 1 pops. During that cycle ra_o shows the entry being popped, which is the jump target. After the edge depth_o has fallen by one.
- R3: A register jump with rd_i=1 and rs1_i other than 1 pushes pc_i+4, exactly as R1 does.
- R4: A register jump with rd_i=1 and rs1_i=1 replaces the top entry with pc_i+4 and leaves depth_o unchanged. If the stack is empty it sets underflow_o and pushes pc_i+4 instead.
- R5: A jump with jump_valid_i=0 leaves the stack unchanged. So does a valid jump that names register 1 neither as destination nor, for a register jump, as base. A PC-relative jump never pops.
- R6: A push onto a full stack, with no pop in the same cycle, sets overflow_o. The flag stays set until reset, and the stack contents and depth are left unchanged.
- R7: A pop from an empty stack sets underflow_o. The flag stays set until reset, and the stack is left unchanged.
- R8: empty_o is 1 exactly when depth_o=0, and full_o is 1 exactly when depth_o=DEPTH. ra_o is 0 when the stack is empty.
- R9: While rst_ni is low the stack is empty and both error flags are clear.
- R10: Successive pops return the entries in the reverse of the order in which they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jump_valid_i | input | 1 | A jump resolves this cycle |
| jump_reg_i | input | 1 | 1: register-based jump, 0: PC-relative jump |
| rd_i | input | 5 | Destination register index |
| rs1_i | input | 5 | Base register index (register jumps only) |
| pc_i | input | 32 | Address of the jump instruction |
| ra_o | output | 32 | Current top entry, used as the target of a pop |
| depth_o | output | 4 | Number of valid entries |
| empty_o | output | 1 | Stack holds no entries |
| full_o | output | 1 | Stack holds DEPTH entries |
| overflow_o | output | 1 | Sticky: a push was attempted while the stack was full |
| underflow_o | output | 1 | Sticky: a pop was attempted while the stack was empty |

## Verification
The bench fills the stack to capacity and pushes once more. A design with a wrong full test would either grow past DEPTH or overwrite the deepest entry, and unwinding all the way would then return a wrong address. Combined push-and-pop jumps are issued on a full stack and on an empty stack. A design that treated the pair as two separate steps would raise a false overflow on the full stack, and on the empty stack it would fail to flag the underflow or fail to push. Pops from an empty stack, jumps that do not name register 1, and PC-relative jumps with base index 1 check that the flags are sticky and that an ignored request does not move the pointer. A long push-then-pop run catches reversed ordering or an off-by-one in the index of the top entry.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam logic [4:0] LINK_REG = 5'd1;
  localparam int unsigned LINK_STEP = 4;

  typedef enum logic [1:0] {
    RAS_NONE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2,
    RAS_SWAP = 2'd3
  } ras_op_e;
endpackage

// File: rtl/ras_link_decode.sv
module ras_link_decode
  import ras_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          jump_valid_i,
  input  logic          jump_reg_i,
  input  logic [4:0]    rd_i,
  input  logic [4:0]    rs1_i,
  input  logic [AW-1:0] pc_i,
  output ras_op_e       op_o,
  output logic [AW-1:0] link_o
);
  logic wr_link, rd_link;

  assign wr_link = jump_valid_i && (rd_i == LINK_REG);
  // only register jumps read a base register
  assign rd_link = jump_valid_i && jump_reg_i && (rs1_i == LINK_REG);
  assign link_o  = pc_i + AW'(LINK_STEP);

  always_comb begin
    unique case ({wr_link, rd_link})
      2'b10:   op_o = RAS_PUSH;
      2'b01:   op_o = RAS_POP;
      2'b11:   op_o = RAS_SWAP;
      default: op_o = RAS_NONE;
    endcase
  end

  a_r5_idle_no_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_valid_i |-> op_o == RAS_NONE);
  a_r5_pcrel_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_reg_i |-> (op_o != RAS_POP && op_o != RAS_SWAP));
endmodule

// File: rtl/ras_store.sv
module ras_store
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ras_op_e          op_i,
  input  logic [AW-1:0]    data_i,
  output logic [AW-1:0]    top_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             unf_evt_o
);
  logic [AW-1:0]    mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, top_pos;
  logic [IDX_W-1:0] top_idx, wr_idx;
  logic             wr_en, empty, full;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_pos = cnt_q - CNT_W'(1);
  assign top_idx = top_pos[IDX_W-1:0];
  assign top_o   = empty ? '0 : mem_q[top_idx];
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d     = cnt_q;
    wr_en     = 1'b0;
    wr_idx    = cnt_q[IDX_W-1:0];
    ovf_evt_o = 1'b0;
    unf_evt_o = 1'b0;
    unique case (op_i)
      RAS_PUSH: begin
        if (full) ovf_evt_o = 1'b1;
        else begin
          wr_en = 1'b1;
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      RAS_POP: begin
        if (empty) unf_evt_o = 1'b1;
        else cnt_d = cnt_q - CNT_W'(1);
      end
      RAS_SWAP: begin
        wr_en = 1'b1;
        if (empty) begin
          // nothing to replace: flag it and push
          unf_evt_o = 1'b1;
          wr_idx    = '0;
          cnt_d     = CNT_W'(1);
        end else begin
          wr_idx = top_idx;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= data_i;
    end
  end

  a_r1_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_PUSH && !full) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r2_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_POP && !empty) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r4_swap_keeps_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_SWAP && !empty) |=> $stable(cnt_q));
  a_r6_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_PUSH && full) |=> ($stable(cnt_q) && $stable(top_o)));
  a_r7_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_POP && empty) |=> cnt_q == '0);
  a_r8_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/ras_err_flags.sv
module ras_err_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_evt_i,
  input  logic unf_evt_i,
  output logic overflow_o,
  output logic underflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      overflow_o  <= overflow_o  | ovf_evt_i;
      underflow_o <= underflow_o | unf_evt_i;
    end
  end

  a_r6_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r7_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  a_r6_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> overflow_o);
  a_r7_underflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_evt_i |=> underflow_o);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             jump_valid_i,
  input  logic             jump_reg_i,
  input  logic [4:0]       rd_i,
  input  logic [4:0]       rs1_i,
  input  logic [AW-1:0]    pc_i,
  output logic [AW-1:0]    ra_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  ras_op_e       op;
  logic [AW-1:0] link;
  logic          ovf_evt, unf_evt;

  ras_link_decode #(.AW(AW)) u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .jump_valid_i (jump_valid_i),
    .jump_reg_i   (jump_reg_i),
    .rd_i         (rd_i),
    .rs1_i        (rs1_i),
    .pc_i         (pc_i),
    .op_o         (op),
    .link_o       (link)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .data_i    (link),
    .top_o     (ra_o),
    .cnt_o     (depth_o),
    .ovf_evt_o (ovf_evt),
    .unf_evt_o (unf_evt)
  );

  ras_err_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ovf_evt_i   (ovf_evt),
    .unf_evt_i   (unf_evt),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  assign empty_o = (depth_o == '0);
  assign full_o  = (depth_o == CNT_W'(DEPTH));

  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
  a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> ra_o == '0);
endmodule

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jv = 1'b0, jr = 1'b0;
  logic [4:0]  rd = '0, rs1 = '0;
  logic [31:0] pc = '0;
  logic [31:0] ra;
  logic [3:0]  depth;
  logic        empty, full, ovf, unf;

  int total = 0, bad = 0;
  logic [31:0] q[$];
  bit m_ovf = 0, m_unf = 0;

  always #10 clk = ~clk;

  ret_addr_stack dut (
    .clk_i(clk), .rst_ni(rst_n), .jump_valid_i(jv), .jump_reg_i(jr),
    .rd_i(rd), .rs1_i(rs1), .pc_i(pc), .ra_o(ra), .depth_o(depth),
    .empty_o(empty), .full_o(full), .overflow_o(ovf), .underflow_o(unf)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [31:0] top;
    top = (q.size() == 0) ? 32'd0 : q[q.size()-1];
    chk(tag, "ra_o", ra, top);
    chk(tag, "depth_o", 32'(depth), 32'(q.size()));
    chk({tag, "/R8"}, "empty_o", 32'(empty), 32'(q.size() == 0));
    chk({tag, "/R8"}, "full_o", 32'(full), 32'(q.size() == D));
    chk(tag, "overflow_o", 32'(ovf), 32'(m_ovf));
    chk(tag, "underflow_o", 32'(unf), 32'(m_unf));
  endtask

  // one jump per cycle; outputs compared before the edge, model updated at it
  task automatic jump(string tag, bit v, bit r, int d, int s, logic [31:0] p);
    bit psh, pop;
    @(negedge clk);
    jv = v; jr = r; rd = 5'(d); rs1 = 5'(s); pc = p;
    #2;
    compare(tag);
    psh = v && d == 1;
    pop = v && r && s == 1;
    if (psh && pop) begin
      if (q.size() == 0) begin m_unf = 1; q.push_back(p + 4); end
      else q[q.size()-1] = p + 4;
    end else if (psh) begin
      if (q.size() == D) m_ovf = 1; else q.push_back(p + 4);
    end else if (pop) begin
      if (q.size() == 0) m_unf = 1; else void'(q.pop_back());
    end
    @(posedge clk);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R9 reset");
    rst_n = 1'b1;
    // R7 pop on empty, then R5 ignored jumps
    jump("R7 pop empty", 1, 1, 0, 1, 32'h100);
    jump("R7 sticky", 0, 0, 0, 0, 0);
    jump("R5 invalid", 0, 1, 1, 1, 32'h200);
    jump("R5 other regs", 1, 1, 5, 7, 32'h204);
    jump("R5 pcrel base1", 1, 0, 0, 1, 32'h208);
    // R1 / R3 pushes, R10 ordering
    jump("R1 jal push", 1, 0, 1, 0, 32'h1000);
    jump("R3 jalr push", 1, 1, 1, 9, 32'h2000);
    jump("R4 swap", 1, 1, 1, 1, 32'h3000);
    for (int i = 0; i < 6; i++) jump("R1 fill", 1, 0, 1, 0, 32'h4000 + 32'(i * 16));
    jump("R8 full", 0, 0, 0, 0, 0);
    jump("R6 push full", 1, 0, 1, 0, 32'h5000);
    jump("R6 push full jalr", 1, 1, 1, 3, 32'h5100);
    jump("R4 swap full", 1, 1, 1, 1, 32'h6000);
    for (int i = 0; i < D; i++) jump("R2 R10 unwind", 1, 1, 0, 1, 32'h7000);
    jump("R7 pop empty again", 1, 1, 0, 1, 32'h7100);
    jump("R4 swap empty", 1, 1, 1, 1, 32'h8000);
    jump("R2 pop", 1, 1, 0, 1, 32'h8100);
    jump("R8 empty", 0, 0, 0, 0, 0);
    // mid-run reset
    jump("R1 pre-reset", 1, 0, 1, 0, 32'h9000);
    @(negedge clk);
    rst_n = 1'b0; jv = 1'b0;
    q.delete(); m_ovf = 0; m_unf = 0;
    #2;
    compare("R9 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) jump("R10 push", 1, 0, 1, 0, 32'hA000 + 32'(i * 8));
    for (int i = 0; i < 4; i++) jump("R10 pop", 1, 1, 2, 1, 32'hB000);
    jump("R7 final", 0, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule